// File: doc/BRIEF.md
# Alternate-Phase Dual-Channel Converter Bus Driver

This block feeds a dual-channel 8-bit digital-to-analog converter that has a single shared parallel data bus. The converter takes a channel-1 word on the rising edge of its clock and a channel-2 word on the falling edge of the same clock. The block makes that converter clock by dividing the system clock by four. It places each channel's word on the bus early enough before the edge that captures it, and it drives an active-low chip select.

Samples arrive on two independent valid/ready ports, one per channel. Each channel has one slot per converter period. If a channel has no new sample when its slot comes up, the last accepted word for that channel is sent again. An enable input starts and stops the stream. The clock always stops after a complete period, and when the stream restarts, chip select goes low one system cycle before the first rising edge.

Top module: `dac_alt_drv`

## Requirements
- R1: During and right after reset, chip select is high, the converter clock is low, the bus is 0x00 and both ready outputs are low.
- R2: While enabled, the converter clock has a period of 4 system cycles. It is high for 2 cycles (starting with the rising edge) and low for 2 cycles.
- R3: At each rising converter-clock edge the bus holds the most recently accepted channel-1 word. At each falling edge it holds the most recently accepted channel-2 word. Bit 7 of the bus is the MSB.
- R4: The bus changes to the channel-2 word one system cycle after the rising edge and to the channel-1 word one system cycle after the falling edge. It is therefore stable for at least one system cycle before each edge.
- R5: The channel-1 ready is high in the system cycle that is two cycles before a rising edge, and only while enable is high. The channel-2 ready is high in the cycle that starts with the rising edge. The two readies are never high together, and every accepted word reaches the converter exactly at the next capture edge for its channel.
- R6: A channel whose valid is low at its slot sends its previous word again (0x00 if no word has been accepted since reset).
- R7: If enable is low in the cycle after a falling edge, the stream stops. From the next cycle on, chip select is high, the clock stays low, the bus holds its value and both ready outputs stay low while enable stays low.
- R8: On restart, chip select falls one system cycle before the first rising edge, while the clock is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Stream enable |
| ch1_valid_i | input | 1 | Channel-1 sample valid |
| ch1_data_i | input | 8 | Channel-1 sample |
| ch1_ready_o | output | 1 | Channel-1 sample taken this cycle |
| ch2_valid_i | input | 1 | Channel-2 sample valid |
| ch2_data_i | input | 8 | Channel-2 sample |
| ch2_ready_o | output | 1 | Channel-2 sample taken this cycle |
| dac_clk_o | output | 1 | Converter clock, system clock divided by 4 |
| dac_cs_no | output | 1 | Active-low chip select |
| dac_data_o | output | 8 | Shared converter data bus |

## Verification
The bench models the converter. It latches the bus at each clock edge into the channel that edge belongs to, and compares the latched word against a per-channel model updated from the handshakes it saw.

- It flags a word that was accepted but replaced before any edge captured it; a design that took samples in the wrong phase would drop words this way.
- It checks that the bus already held the captured word one cycle before the edge; a design that switched the bus on the edge itself would fail this.
- It drives long stretches with no valid, to show that a design that sends a stale or zero word instead of repeating the last one is caught.
- It toggles enable at random, including every cycle, to catch:
  - a clock that stops mid-period;
  - chip select that falls in the same cycle as the clock;
  - a ready that is raised while the stream is stopped.

// File: rtl/dac_alt_pkg.sv
package dac_alt_pkg;
  typedef enum logic [1:0] {
    PH_HI0 = 2'd0,
    PH_HI1 = 2'd1,
    PH_LO0 = 2'd2,
    PH_LO1 = 2'd3
  } phase_e;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dac_alt_timing.sv
module dac_alt_timing
  import dac_alt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic              active_o,
  output logic              sclk_o,
  output logic [NUM_CH-1:0] take_o
);
  phase_e ph_q, ph_d;
  logic   act_q, act_d, clk_q, clk_d;

  always_comb begin
    ph_d  = ph_q;
    act_d = act_q;
    clk_d = clk_q;
    unique case (ph_q)
      PH_HI0: ph_d = PH_HI1;
      PH_HI1: begin ph_d = PH_LO0; clk_d = 1'b0; end
      // idle parks here; stop/start decided only at this period boundary
      PH_LO0: begin
        if (en_i) begin ph_d = PH_LO1; act_d = 1'b1; end
        else      act_d = 1'b0;
      end
      PH_LO1: begin ph_d = PH_HI0; clk_d = 1'b1; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_LO0;
      act_q <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      act_q <= act_d;
      clk_q <= clk_d;
    end
  end

  // slot 0 loads the bus before the rise, slot 1 before the fall
  assign take_o[0] = (ph_q == PH_LO0) && en_i;
  assign take_o[1] = (ph_q == PH_HI0);
  assign active_o  = act_q;
  assign sclk_o    = clk_q;

  assert_idle_clk_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !clk_q);
  assert_select_before_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |=> $rose(clk_q));
  assert_high_two_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_q) |=> clk_q);
  assert_low_two_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_q) |=> !clk_q);
  assert_one_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take_o));
endmodule

// File: rtl/dac_alt_slot.sv
module dac_alt_slot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] last_q;
  logic              hit;

  assign hit     = take_i && valid_i;
  assign ready_o = take_i;
  assign word_o  = hit ? data_i : last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_q <= '0;
    else if (hit) last_q <= data_i;
  end

  assert_repeat_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !valid_i) |=> $stable(last_q));
endmodule

// File: rtl/dac_alt_bus.sv
module dac_alt_bus
  import dac_alt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CH-1:0]            load_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] word_i,
  input  logic                         sclk_i,
  output logic [DATA_W-1:0]            bus_o
);
  logic [DATA_W-1:0] bus_q, bus_d;

  always_comb begin
    bus_d = bus_q;
    for (int i = 0; i < int'(NUM_CH); i++)
      if (load_i[i]) bus_d = word_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_q <= '0;
    else         bus_q <= bus_d;
  end

  assign bus_o = bus_q;

  assert_bus_steady_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_i) |-> $stable(bus_q));
  assert_bus_steady_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_i) |-> $stable(bus_q));
endmodule

// File: rtl/dac_alt_drv.sv
module dac_alt_drv
  import dac_alt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ch1_valid_i,
  input  logic [DATA_W-1:0] ch1_data_i,
  output logic              ch1_ready_o,
  input  logic              ch2_valid_i,
  input  logic [DATA_W-1:0] ch2_data_i,
  output logic              ch2_ready_o,
  output logic              dac_clk_o,
  output logic              dac_cs_no,
  output logic [DATA_W-1:0] dac_data_o
);
  logic [NUM_CH-1:0]             take, valid, ready;
  logic [NUM_CH-1:0][DATA_W-1:0] din, word;
  logic                          active, sclk;

  assign valid = {ch2_valid_i, ch1_valid_i};
  assign din   = {ch2_data_i, ch1_data_i};

  dac_alt_timing u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .active_o(active),
    .sclk_o  (sclk),
    .take_o  (take)
  );

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_slot
    dac_alt_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (take[g]),
      .valid_i(valid[g]),
      .data_i (din[g]),
      .ready_o(ready[g]),
      .word_o (word[g])
    );
  end

  dac_alt_bus #(.DATA_W(DATA_W)) u_bus (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(take),
    .word_i(word),
    .sclk_i(sclk),
    .bus_o (dac_data_o)
  );

  assign ch1_ready_o = ready[0];
  assign ch2_ready_o = ready[1];
  assign dac_clk_o   = sclk;
  assign dac_cs_no   = !active;

  assert_no_ready_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && dac_cs_no) |-> !(ch1_ready_o || ch2_ready_o));
  assert_cs_high_clk_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_cs_no |-> !dac_clk_o);
endmodule

// File: tb/dac_alt_drv_tb.sv
module dac_alt_drv_tb_top;
  localparam int W = 8;
  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic v1 = 1'b0, v2 = 1'b0;
  logic [W-1:0] d1 = '0, d2 = '0;
  logic r1, r2, sclk, cs_n;
  logic [W-1:0] bus;

  always #2 clk_i = ~clk_i;

  dac_alt_drv #(.DATA_W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .ch1_valid_i(v1), .ch1_data_i(d1), .ch1_ready_o(r1),
    .ch2_valid_i(v2), .ch2_data_i(d2), .ch2_ready_o(r2),
    .dac_clk_o(sclk), .dac_cs_no(cs_n), .dac_data_o(bus));

  int checks = 0, errors = 0, cyc = 0, mode = 0, hold = 0, seed_v;
  bit running = 0, done = 0;
  logic [W-1:0] exp1 = '0, exp2 = '0, bus_prev = '0;
  logic clk_prev = 1'b0, cs_prev = 1'b1;
  bit fresh1 = 0, fresh2 = 0, after_rise = 0, after_fall = 0, arm_pend = 0, rise_ok = 0;
  int last_rise = 0;

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  always @(negedge clk_i) begin
    if (running) begin
      cyc++;
      if (after_rise) chk(bus == exp2, "R4 ch2 word on bus one cycle after rise", bus, exp2);
      if (after_fall && !cs_n) chk(bus == exp1, "R4 ch1 word on bus one cycle after fall", bus, exp1);
      if (arm_pend) chk(sclk == 1'b1, "R8 clock rises one cycle after select", sclk, 1);
      after_rise = 0; after_fall = 0; arm_pend = 0;
      if (sclk && !clk_prev) begin
        chk(bus == exp1, "R3 ch1 capture at rise", bus, exp1);
        chk(bus == bus_prev, "R4 bus stable before rise", bus, bus_prev);
        chk(!cs_n, "R8 select low at rise", cs_n, 0);
        if (rise_ok) chk(cyc - last_rise == 4, "R2 period", cyc - last_rise, 4);
        last_rise = cyc; rise_ok = 1; fresh1 = 0; after_rise = 1;
      end
      if (!sclk && clk_prev) begin
        chk(bus == exp2, "R3 ch2 capture at fall", bus, exp2);
        chk(bus == bus_prev, "R4 bus stable before fall", bus, bus_prev);
        chk(cyc - last_rise == 2, "R2 high time", cyc - last_rise, 2);
        fresh2 = 0; after_fall = 1;
      end
      if (!cs_n && cs_prev) begin
        chk(!sclk, "R8 clock low when select falls", sclk, 0);
        arm_pend = 1;
      end
      if (cs_n) begin
        rise_ok = 0;
        if (cs_prev) chk(!sclk && bus == bus_prev, "R7 stopped: clock low, bus held",
                         {sclk, bus}, {1'b0, bus_prev});
      end
      clk_prev = sclk; cs_prev = cs_n; bus_prev = bus;

      // drive
      d1 = W'($urandom); d2 = W'($urandom);
      case (mode)
        0: begin en_i = 1; v1 = 1; v2 = 1; end
        1: begin en_i = 1; v1 = 0; v2 = 0; end
        2: begin
          v1 = ($urandom % 2) == 0; v2 = ($urandom % 3) != 0;
          if (hold > 0) hold--;
          else begin en_i = ~en_i; hold = en_i ? int'($urandom % 40) : int'($urandom % 12); end
        end
        default: begin en_i = $urandom % 2; v1 = $urandom % 2; v2 = $urandom % 2; end
      endcase
      #1;
      if (!en_i && cs_n) chk(!r1 && !r2, "R7 no ready while stopped", {r1, r2}, 0);
      if (r1 && r2) chk(0, "R5 both readies high", 3, 1);
      if (r1 && v1) begin
        if (fresh1) chk(0, "R5 ch1 word dropped before capture", 1, 0);
        exp1 = d1; fresh1 = 1;
      end
      if (r2 && v2) begin
        if (fresh2) chk(0, "R5 ch2 word dropped before capture", 1, 0);
        exp2 = d2; fresh2 = 1;
      end
    end
  end

  initial begin
    seed_v = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk_i);
    chk(cs_n == 1'b1, "R1 reset select high", cs_n, 1);
    chk(sclk == 1'b0, "R1 reset clock low", sclk, 0);
    chk(bus == '0, "R1 reset bus zero", bus, 0);
    chk(!r1 && !r2, "R1 reset readies low", {r1, r2}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_n && !sclk && bus == '0, "R1 idle after reset", {cs_n, sclk, bus}, 10'h200);
    running = 1;
    mode = 1; repeat (40)   @(posedge clk_i); // R6 zero repeated before any word
    mode = 0; repeat (3000) @(posedge clk_i);
    mode = 1; repeat (600)  @(posedge clk_i); // R6 repeat last
    mode = 2; repeat (8000) @(posedge clk_i);
    mode = 3; repeat (3000) @(posedge clk_i);
    mode = 0; repeat (200)  @(posedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule